// File: doc/BRIEF.md
# Smart Card Power Sequencer

This controller powers a contact smart card up and down in a fixed order. A host drives an active-low command line, and a card-detect input reports whether a card is in the slot. The detect input can be set to either polarity. A separate fault monitor raises a fault request, and a free-running oscillator supplies single-cycle tick pulses.

The controller drives five enables, one for each stage of the card interface: the step-up converter, the card supply regulator, the I/O transceivers, the card clock gate and the card reset line. On power-up the enables switch on one at a time, from the step-up converter to the reset release. On power-down they switch off in the reverse order, so reset goes low first. The I/O stays three-stated from the clock stop until both supplies are off. A programmable number of oscillator ticks separates consecutive steps. An `active` status output tells the host when the card is fully running.

Stop requests that arrive while power-up is in progress are held until power-up is complete. Card removal stops the card at once from whatever step it has reached.

Top module: `scard_seq`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, all five enables and `active` are 0.
- R2: Power-up starts only when a high-to-low transition of `cmd_n` is sampled while the card is present. A `cmd_n` that was already low at reset, or that stays low, does not start it. A falling edge with no card present does not start it either.
- R3: With `present_pol`=1 the card is present when `present_raw`=1. With `present_pol`=0 it is present when `present_raw`=0.
- R4: Power-up order is `en_boost`, `en_supply`, `en_io`, `en_clk`, then `rst_card`=1. `en_boost` rises on the clock that samples the start edge. Each later step comes on the clock that samples the `gap_ticks`-th tick pulse after the previous step. A `gap_ticks` of 0 acts as 1.
- R5: `active` is 1 exactly when all five enables are 1.
- R6: When `cmd_n` is sampled high while active, `rst_card` goes to 0 on that clock. Then `en_clk`, `en_io`, `en_supply` and `en_boost` go to 0 in that order, using the same tick spacing as R4.
- R7: A `fault_req` sampled while active drops `rst_card` on that clock and starts the power-down of R6.
- R8: A `fault_req` pulse or a high `cmd_n` during power-up does not shorten it. Power-up completes, `active` is 1 for exactly one clock, and then power-down starts.
- R9: Card removal sampled during power-up or while active drops the highest enabled output on that clock. Power-down then continues with normal spacing. If only `en_boost` was on, the block returns to idle at once.
- R10: A `cmd_n` falling edge during power-down is ignored. After power-down, a new power-up needs a new falling edge.
- R11: The enables form a chain: `en_supply` implies `en_boost`, `en_io` implies `en_supply`, `en_clk` implies `en_io`, and `rst_card` implies `en_clk`. At most one enable changes per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Single-cycle oscillator tick pulse |
| cmd_n | input | 1 | Host command, low requests the card powered |
| present_raw | input | 1 | Card-detect level from the slot |
| present_pol | input | 1 | 1: detect active high, 0: detect active low |
| fault_req | input | 1 | Stop request from the fault monitor |
| gap_ticks | input | GAP_W | Ticks between consecutive steps |
| en_boost | output | 1 | Step-up converter enable |
| en_supply | output | 1 | Card supply regulator enable |
| en_io | output | 1 | I/O transceiver enable, 0 means three-state |
| en_clk | output | 1 | Card clock gate enable |
| rst_card | output | 1 | Card reset line, 1 means released |
| active | output | 1 | Card fully powered and out of reset |

## Verification
The assertions assume that every input is already synchronous to `clk`. A start edge is judged from the `cmd_n` and detect values of the previous sample. The bench changes inputs only on the falling clock edge. It raises `fault_req` and `tick` as pulses, and it changes `gap_ticks` only while the reference model is idle, so the tick spacing never moves in the middle of a sequence. Random phases toggle the command and detect lines rarely enough that many sequences run to completion. Directed cases cover the deferred-stop and removal corners.

// File: rtl/scard_pkg.sv
// Package: shared state encoding and step count for the card power sequencer.
// Assumes: the number of power steps is fixed at five by the interface.
package scard_pkg;
    localparam int NSTEP = 5;
    localparam int LVL_W = $clog2(NSTEP + 1);

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_RAMP_UP = 2'd1,
        SEQ_ON      = 2'd2,
        SEQ_RAMP_DN = 2'd3
    } seq_state_t;
endpackage

// File: rtl/scard_cond.sv
// Module: conditions the host and detect inputs.
// Produces a card-present level of the selected polarity and a falling-edge
// strobe of the host command. Assumes both inputs are synchronous to clk.
// The edge register resets to 0, so a command held low through reset is not an edge.
module scard_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_n,
    input  logic present_raw,
    input  logic present_pol,
    output logic present,
    output logic cmd_fall
);
    logic cmd_q;

    // Remember the previous command level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= 1'b0;
        else        cmd_q <= cmd_n;
    end

    // Polarity select and edge strobe.
    always_comb begin
        present  = present_pol ? present_raw : ~present_raw;
        cmd_fall = cmd_q & ~cmd_n;
    end
endmodule

// File: rtl/scard_spacer.sv
// Module: counts oscillator ticks between sequence steps.
// Emits step on the tick that completes gap ticks since the last clear or step.
// A gap of 0 behaves as 1. Assumes tick is a one-cycle pulse.
module scard_spacer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic [GAP_W-1:0] gap,
    output logic             step
);
    logic [GAP_W-1:0] cnt_q;
    logic             reach;

    // Decide whether this tick closes the gap.
    always_comb begin
        reach = ({1'b0, cnt_q} + (GAP_W+1)'(1)) >= {1'b0, gap};
        step  = run & tick & reach;
    end

    // Tick counter, restarted on clear or on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (clr || step)   cnt_q <= '0;
        else if (run && tick)   cnt_q <= cnt_q + GAP_W'(1);
    end
endmodule

// File: rtl/scard_rail_dec.sv
// Module: decodes the power level into the per-stage enables.
// Level n turns on the first n stages, which keeps the chain ordered by
// construction. Assumes level never exceeds the step count.
module scard_rail_dec
    import scard_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    output logic [NSTEP-1:0] en_vec
);
    // One comparator per stage.
    for (genvar i = 0; i < NSTEP; i++) begin : g_stage
        assign en_vec[i] = (lvl > LVL_W'(i));
    end
endmodule

// File: rtl/scard_seq.sv
// Module: top-level card power sequencer.
// A level counter steps up from 0 to 5 during power-up and back down during
// power-down, paced by the tick spacer. Stop requests raised during power-up
// are held in a pending flag. Card removal interrupts at once.
// Assumes all inputs are synchronous to clk.
module scard_seq
    import scard_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_n,
    input  logic             present_raw,
    input  logic             present_pol,
    input  logic             fault_req,
    input  logic [GAP_W-1:0] gap_ticks,
    output logic             en_boost,
    output logic             en_supply,
    output logic             en_io,
    output logic             en_clk,
    output logic             rst_card,
    output logic             active
);
    seq_state_t       state_q, state_d;
    logic [LVL_W-1:0] lvl_q, lvl_d;
    logic             pend_q, pend_d;
    logic             present, cmd_fall, step, clr, run, start, stop_req;
    logic [NSTEP-1:0] en_vec;

    scard_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_n      (cmd_n),
        .present_raw(present_raw),
        .present_pol(present_pol),
        .present    (present),
        .cmd_fall   (cmd_fall)
    );

    scard_spacer #(.GAP_W(GAP_W)) u_gap (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .run  (run),
        .tick (tick),
        .gap  (gap_ticks),
        .step (step)
    );

    scard_rail_dec u_dec (
        .lvl   (lvl_q),
        .en_vec(en_vec)
    );

    // Next-state, level and pending-stop logic.
    always_comb begin
        state_d  = state_q;
        lvl_d    = lvl_q;
        clr      = 1'b0;
        run      = (state_q == SEQ_RAMP_UP) || (state_q == SEQ_RAMP_DN);
        start    = (state_q == SEQ_IDLE) && cmd_fall && present;
        stop_req = cmd_n | fault_req | pend_q | ~present;
        pend_d   = ((state_q == SEQ_RAMP_UP) || start) && (pend_q | fault_req | cmd_n);
        case (state_q)
            SEQ_IDLE: begin
                if (start) begin
                    state_d = SEQ_RAMP_UP;
                    lvl_d   = LVL_W'(1);
                    clr     = 1'b1;
                end
            end
            SEQ_RAMP_UP: begin
                if (!present) begin
                    lvl_d   = lvl_q - LVL_W'(1);
                    clr     = 1'b1;
                    state_d = (lvl_q == LVL_W'(1)) ? SEQ_IDLE : SEQ_RAMP_DN;
                end else if (step) begin
                    lvl_d = lvl_q + LVL_W'(1);
                    if (lvl_q == LVL_W'(NSTEP - 1)) state_d = SEQ_ON;
                end
            end
            SEQ_ON: begin
                if (stop_req) begin
                    lvl_d   = lvl_q - LVL_W'(1);
                    clr     = 1'b1;
                    state_d = SEQ_RAMP_DN;
                end
            end
            SEQ_RAMP_DN: begin
                if (step) begin
                    lvl_d = lvl_q - LVL_W'(1);
                    if (lvl_q == LVL_W'(1)) state_d = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            lvl_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            pend_q  <= pend_d;
        end
    end

    // Output mapping.
    always_comb begin
        en_boost  = en_vec[0];
        en_supply = en_vec[1];
        en_io     = en_vec[2];
        en_clk    = en_vec[3];
        rst_card  = en_vec[4];
        active    = (state_q == SEQ_ON);
    end
endmodule

// File: rtl/scard_seq_chk.sv
// Module: property checker for the card power sequencer, bound to its top.
// Assumes inputs synchronous to clk and a synchronous active-low reset.
module scard_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_n,
    input logic present_raw,
    input logic present_pol,
    input logic fault_req,
    input logic en_boost,
    input logic en_supply,
    input logic en_io,
    input logic en_clk,
    input logic rst_card,
    input logic active
);
    logic       pres;
    logic [4:0] vec;

    // Observed presence and enable vector.
    always_comb begin
        pres = present_pol ? present_raw : ~present_raw;
        vec  = {rst_card, en_clk, en_io, en_supply, en_boost};
    end

    p_chain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_supply || en_boost) && (!en_io || en_supply) &&
        (!en_clk || en_io) && (!rst_card || en_clk));

    p_single_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vec ^ $past(vec)) <= 1);

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_boost) |-> (!$past(cmd_n) && $past(pres)));

    p_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active == (&vec));

    p_rst_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> (!rst_card && en_clk));

    p_fault_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fault_req) |=> (!rst_card && en_clk));
endmodule

bind scard_seq scard_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_n      (cmd_n),
    .present_raw(present_raw),
    .present_pol(present_pol),
    .fault_req  (fault_req),
    .en_boost   (en_boost),
    .en_supply  (en_supply),
    .en_io      (en_io),
    .en_clk     (en_clk),
    .rst_card   (rst_card),
    .active     (active)
);

// File: tb/tb_scard_seq.sv
// Bench: directed corner cases plus seeded random phases, compared each
// cycle against a reference model built from the requirements.
module tb_scard_seq;
    localparam int GAP_W = 8;

    logic             clk = 1'b0;
    logic             rst_n, tick, cmd_n, present_raw, present_pol, fault_req;
    logic [GAP_W-1:0] gap_ticks;
    logic             en_boost, en_supply, en_io, en_clk, rst_card, active;

    int checks = 0;
    int fails  = 0;
    int tper   = 3;
    int tk     = 0;
    bit rnd_tick = 1'b0;

    // Reference model state.
    int   m_st, m_lvl, m_cnt;
    logic m_pend, m_cmdq;

    always #2 clk = ~clk;

    scard_seq #(.GAP_W(GAP_W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_n(cmd_n),
        .present_raw(present_raw), .present_pol(present_pol),
        .fault_req(fault_req), .gap_ticks(gap_ticks),
        .en_boost(en_boost), .en_supply(en_supply), .en_io(en_io),
        .en_clk(en_clk), .rst_card(rst_card), .active(active)
    );

    // Reference model: 0 idle, 1 power-up, 2 active, 3 power-down.
    always @(posedge clk) begin
        logic pres, fall, stp, strt;
        pres = present_pol ? present_raw : ~present_raw;
        fall = m_cmdq & ~cmd_n;
        stp  = tick && ((m_cnt + 1) >= int'(gap_ticks));
        if (!rst_n) begin
            m_st <= 0; m_lvl <= 0; m_cnt <= 0; m_pend <= 1'b0; m_cmdq <= 1'b0;
        end else begin
            strt = (m_st == 0) && fall && pres;
            m_cmdq <= cmd_n;
            m_pend <= ((m_st == 1) || strt) && (m_pend || fault_req || cmd_n);
            case (m_st)
                0: if (strt) begin m_st <= 1; m_lvl <= 1; m_cnt <= 0; end
                1: begin
                    if (!pres) begin
                        m_lvl <= m_lvl - 1; m_cnt <= 0;
                        m_st  <= (m_lvl == 1) ? 0 : 3;
                    end else if (stp) begin
                        m_lvl <= m_lvl + 1; m_cnt <= 0;
                        if (m_lvl == 4) m_st <= 2;
                    end else if (tick) m_cnt <= m_cnt + 1;
                end
                2: if (cmd_n || fault_req || m_pend || !pres) begin
                    m_st <= 3; m_lvl <= 4; m_cnt <= 0;
                end
                default: begin
                    if (stp) begin
                        m_lvl <= m_lvl - 1; m_cnt <= 0;
                        if (m_lvl == 1) m_st <= 0;
                    end else if (tick) m_cnt <= m_cnt + 1;
                end
            endcase
        end
    end

    function automatic logic [5:0] expect_vec(int st, int lvl);
        return {st == 2, lvl > 4, lvl > 3, lvl > 2, lvl > 1, lvl > 0};
    endfunction

    function automatic string tag_of(int st);
        case (st)
            0: return "R2";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_bit(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Compare all outputs with the model and check the chain invariant.
    task automatic compare(string tag);
        logic [5:0] got;
        logic [5:0] exp;
        got = {active, rst_card, en_clk, en_io, en_supply, en_boost};
        exp = expect_vec(m_st, m_lvl);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: outputs %b expected %b", tag, got, exp);
        end
        checks++;
        if ((en_supply && !en_boost) || (en_io && !en_supply) ||
            (en_clk && !en_io) || (rst_card && !en_clk)) begin
            fails++;
            $display("FAIL R11: chain %b expected ordered", got[4:0]);
        end
    endtask

    // Advance n cycles, checking at each falling edge, then drive the tick.
    task automatic run(int n, string tag);
        repeat (n) begin
            @(negedge clk);
            compare(tag);
            if (rnd_tick) tick = (($urandom % tper) == 0);
            else          tick = ((tk % tper) == 0);
            tk++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst_n = 1'b0; tick = 1'b0; cmd_n = 1'b1; present_raw = 1'b1;
        present_pol = 1'b1; fault_req = 1'b0; gap_ticks = GAP_W'(2);
        run(3, "R1");
        check_bit("R1", en_boost | active, 1'b0);
        rst_n = 1'b1;
        run(2, "R1");

        // R4 power-up order and spacing, then R6 power-down on command high.
        cmd_n = 1'b0; run(40, "R4");
        check_bit("R5", active, 1'b1);
        cmd_n = 1'b1; run(40, "R6");
        check_bit("R6", en_boost, 1'b0);

        // R2: no start without card, no start without a fresh edge.
        present_raw = 1'b0; cmd_n = 1'b0; run(10, "R2");
        present_raw = 1'b1; run(10, "R2");
        check_bit("R2", en_boost, 1'b0);

        // R3: active-low detect polarity.
        cmd_n = 1'b1; present_pol = 1'b0; present_raw = 1'b0; run(3, "R3");
        cmd_n = 1'b0; run(40, "R3");
        check_bit("R3", active, 1'b1);

        // R7: fault while active.
        fault_req = 1'b1; run(1, "R7"); fault_req = 1'b0;
        check_bit("R7", rst_card, 1'b0);
        run(40, "R7");

        // R8: fault pulse during power-up, with unit gap and tick every cycle.
        present_pol = 1'b1; present_raw = 1'b1; gap_ticks = '0; tper = 1;
        cmd_n = 1'b1; run(2, "R8");
        cmd_n = 1'b0; run(2, "R8");
        fault_req = 1'b1; run(1, "R8"); fault_req = 1'b0;
        run(30, "R8");
        check_bit("R8", en_boost, 1'b0);

        // R9: card removal during power-up.
        gap_ticks = GAP_W'(3); tper = 2;
        cmd_n = 1'b1; run(2, "R9");
        cmd_n = 1'b0; run(14, "R9");
        present_raw = 1'b0; run(40, "R9");
        check_bit("R9", en_boost, 1'b0);
        present_raw = 1'b1;

        // R10: falling edge during power-down is ignored.
        cmd_n = 1'b1; run(2, "R10");
        cmd_n = 1'b0; run(50, "R10");
        cmd_n = 1'b1; run(3, "R10");
        cmd_n = 1'b0; run(60, "R10");
        check_bit("R10", en_boost, 1'b0);

        // Random phase.
        rnd_tick = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            compare(tag_of(m_st));
            tick = (($urandom % tper) == 0);
            if (($urandom % 40) == 0) cmd_n = ~cmd_n;
            if (($urandom % 300) == 0) present_raw = ~present_raw;
            fault_req = (($urandom % 120) == 0);
            if (m_st == 0 && m_lvl == 0 && ($urandom % 8) == 0) begin
                gap_ticks = GAP_W'($urandom % 4);
                tper = 1 + int'($urandom % 3);
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule